// File: doc/BRIEF.md
# Ping-Pong Integrator Sequencer

This block sequences a charge digitizer in which every input owns two integrating sides, A and B, and a single converter is shared among them. While one side collects charge, the other side goes through a measure, reset and auto-zero pass. The controller samples the level (never the edges) of an external conversion-control input. It also watches an internal measurement-busy flag. From these it chooses which side integrates, fires a start strobe whenever a measurement pass begins, and reports whether the sequencer is running continuously or has had to stop integration and wait for the converter.

The busy flag comes from an internal down-counter. The counter is loaded with `MEAS_CYCLES` when a pass starts, and one pass digitizes both inputs in turn. If the conversion-control level changes while a pass is still running, the sequencer falls into a non-continuous branch. In that branch both sides stop integrating. The running pass finishes, the pass owed to the other side is run, and then a side is prepared before continuous operation resumes. A one-cycle ready pulse marks the end of every pass. The conversion input is plain control and is synchronized inside the block; there is no data stream at the block edge, so no valid/ready handshake applies.

Top module: `pingpong_seq`

## Requirements
- R1: While `rst_n` is low, the stage becomes 0 if the synchronized conversion input is high and 7 if it is low. The timer is idle, and all strobes, the busy flag, the ready pulse, both integrate controls and the mode flag are low.
- R2: `stage_o` holds the stage number minus one (stage 1 = 0 … stage 8 = 7). `int_a_o` is high in stages 3 and 5, `int_b_o` is high in stages 4 and 6, and `cont_mode_o` is high in stages 3 to 6 and low in all other stages.
- R3: `conv_i` passes through `SYNC_STAGES` flops before the sequencer uses it. A level change therefore moves the stage on the `SYNC_STAGES+1`-th rising edge after it is applied. Only the level matters.
- R4: Continuous moves (c = synchronized conversion level, m = busy flag): 3→4 when c is low. 6→5 when c is high. 4→5 when c is high and m is low. 4→6 when c is low and m is low. 5→4 when c is low and m is low. 5→3 when c is high and m is low.
- R5: `meas_start_a_o` pulses for one cycle in the first cycle of every entry into stage 4. `meas_start_b_o` does the same for stage 5. A pass only starts while the timer is idle.
- R6: `meas_busy_o` is high from the first cycle of a pass for exactly `MEAS_CYCLES` cycles. It also stays high while a pass is still owed to the other side.
- R7: In stage 4, a high c while m is high moves to stage 1. In stage 5, a low c while m is high moves to stage 8. Integration stops in both stages 1 and 8.
- R8: Stage 1 holds while m is high. Once its running pass ends, if it was entered from stage 4 it starts a side-B pass (strobe on `meas_start_b_o`) and holds again. It moves to stage 2 when m is low. Stage 8 mirrors this, with a side-A pass, moving to stage 7.
- R9: Stage 2 moves to 3 when c is high and m is low. Stage 7 moves to 6 when c is low and m is low. Otherwise both hold.
- R10: `data_ready_o` pulses for one cycle in the first cycle after each pass's busy period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_i | input | 1 | Conversion-control level, asynchronous |
| int_a_o | output | 1 | Side A integrating |
| int_b_o | output | 1 | Side B integrating |
| meas_start_a_o | output | 1 | One-cycle strobe: pass on side A begins |
| meas_start_b_o | output | 1 | One-cycle strobe: pass on side B begins |
| meas_busy_o | output | 1 | Measurement busy flag |
| cont_mode_o | output | 1 | High in continuous stages |
| data_ready_o | output | 1 | One-cycle pulse at the end of a pass |
| stage_o | output | 3 | Current stage number minus one |

## Verification
A conversion-level change applied between edges reaches `stage_o` on the `SYNC_STAGES+1`-th rising edge. Start strobes, the busy flag and the integrate controls change on that same edge. `data_ready_o` follows a strobe by exactly `MEAS_CYCLES` edges. The bench advances a cycle model of these rules on each rising edge and compares every output with it at the following falling edge. A directed check counts the synchronizer delay cycle by cycle, and randomized hold lengths shorter and longer than a pass drive the sequencer through both the continuous and the overrun branches.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  typedef enum logic [2:0] {
    ST_DRAIN_A    = 3'd0,
    ST_PREP_A     = 3'd1,
    ST_INT_A      = 3'd2,
    ST_INTB_MEASA = 3'd3,
    ST_INTA_MEASB = 3'd4,
    ST_INT_B      = 3'd5,
    ST_PREP_B     = 3'd6,
    ST_DRAIN_B    = 3'd7
  } stage_e;

  function automatic logic stage_is_cont(stage_e s);
    return (s == ST_INT_A) || (s == ST_INTB_MEASA) ||
           (s == ST_INTA_MEASB) || (s == ST_INT_B);
  endfunction

  function automatic logic stage_int_a(stage_e s);
    return (s == ST_INT_A) || (s == ST_INTA_MEASB);
  endfunction

  function automatic logic stage_int_b(stage_e s);
    return (s == ST_INT_B) || (s == ST_INTB_MEASA);
  endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk) q_r <= d_i;
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] sh_r;
      always_ff @(posedge clk) sh_r <= {sh_r[STAGES-2:0], d_i};
      assign q_o = sh_r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/meas_timer.sv
module meas_timer #(
  parameter int MEAS_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(MEAS_CYCLES + 1);

  logic [CW-1:0] cnt_r;
  logic          done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= (cnt_r == CW'(1));
      if (start_i)
        cnt_r <= CW'(MEAS_CYCLES);
      else if (cnt_r != '0)
        cnt_r <= cnt_r - CW'(1);
    end
  end

  assign busy_o = (cnt_r != '0);
  assign done_o = done_r;

  // R6: a pass begins only on an idle timer and is loaded with the full length
  a_r6_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_r == '0));
  a_r6_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && cnt_r == CW'(MEAS_CYCLES)));
  // R10: completion pulse only right after a busy period
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pingpong_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   conv_s,
  input  logic   tmr_busy,
  output stage_e stage_o,
  output logic   start_a_o,
  output logic   start_b_o,
  output logic   mbsy_o
);
  stage_e stage_q, stage_d;
  logic   owe_q, owe_d;
  logic   mbsy;

  assign mbsy = tmr_busy | owe_q;

  always_comb begin
    stage_d   = stage_q;
    owe_d     = owe_q;
    start_a_o = 1'b0;
    start_b_o = 1'b0;
    case (stage_q)
      ST_DRAIN_A: begin
        if (owe_q && !tmr_busy) begin
          start_b_o = 1'b1;
          owe_d     = 1'b0;
        end else if (!mbsy) begin
          stage_d = ST_PREP_A;
        end
      end
      ST_PREP_A: if (conv_s && !mbsy) stage_d = ST_INT_A;
      ST_INT_A: begin
        if (!conv_s) begin
          stage_d   = ST_INTB_MEASA;
          start_a_o = 1'b1;
        end
      end
      ST_INTB_MEASA: begin
        if (conv_s && !mbsy) begin
          stage_d   = ST_INTA_MEASB;
          start_b_o = 1'b1;
        end else if (conv_s && mbsy) begin
          stage_d = ST_DRAIN_A;
          owe_d   = 1'b1;
        end else if (!mbsy) begin
          stage_d = ST_INT_B;
        end
      end
      ST_INTA_MEASB: begin
        if (!conv_s && !mbsy) begin
          stage_d   = ST_INTB_MEASA;
          start_a_o = 1'b1;
        end else if (!conv_s && mbsy) begin
          stage_d = ST_DRAIN_B;
          owe_d   = 1'b1;
        end else if (!mbsy) begin
          stage_d = ST_INT_A;
        end
      end
      ST_INT_B: begin
        if (conv_s) begin
          stage_d   = ST_INTA_MEASB;
          start_b_o = 1'b1;
        end
      end
      ST_PREP_B: if (!conv_s && !mbsy) stage_d = ST_INT_B;
      ST_DRAIN_B: begin
        if (owe_q && !tmr_busy) begin
          start_a_o = 1'b1;
          owe_d     = 1'b0;
        end else if (!mbsy) begin
          stage_d = ST_PREP_B;
        end
      end
      default: stage_d = conv_s ? ST_DRAIN_A : ST_DRAIN_B;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= conv_s ? ST_DRAIN_A : ST_DRAIN_B;
      owe_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      owe_q   <= owe_d;
    end
  end

  assign stage_o = stage_q;
  assign mbsy_o  = mbsy;

  // R5: new passes only start on an idle timer
  a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a_o || start_b_o) |-> !tmr_busy);
  // R4: low conversion level leaves the side-A-only stage
  a_r4_leave_int_a: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_INT_A && !conv_s) |=> (stage_q == ST_INTB_MEASA));
  // R7: level change during a busy pass drops to the drain stage
  a_r7_overrun_a: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_INTB_MEASA && conv_s && tmr_busy) |=> (stage_q == ST_DRAIN_A));
  a_r7_overrun_b: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_INTA_MEASB && !conv_s && tmr_busy) |=> (stage_q == ST_DRAIN_B));
  // R8: drain stages hold while busy
  a_r8_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_DRAIN_A && mbsy) |=> (stage_q == ST_DRAIN_A));
endmodule

// File: rtl/pingpong_seq.sv
module pingpong_seq
  import pingpong_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_i,
  output logic       int_a_o,
  output logic       int_b_o,
  output logic       meas_start_a_o,
  output logic       meas_start_b_o,
  output logic       meas_busy_o,
  output logic       cont_mode_o,
  output logic       data_ready_o,
  output logic [2:0] stage_o
);
  logic   conv_s;
  logic   tmr_busy, tmr_done;
  logic   st_a, st_b, mbsy;
  stage_e stage;
  logic   sa_q, sb_q;

  level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (conv_i),
    .q_o (conv_s)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_s    (conv_s),
    .tmr_busy  (tmr_busy),
    .stage_o   (stage),
    .start_a_o (st_a),
    .start_b_o (st_b),
    .mbsy_o    (mbsy)
  );

  meas_timer #(.MEAS_CYCLES(MEAS_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (st_a | st_b),
    .busy_o  (tmr_busy),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa_q <= 1'b0;
      sb_q <= 1'b0;
    end else begin
      sa_q <= st_a;
      sb_q <= st_b;
    end
  end

  assign int_a_o        = stage_int_a(stage);
  assign int_b_o        = stage_int_b(stage);
  assign cont_mode_o    = stage_is_cont(stage);
  assign meas_start_a_o = sa_q;
  assign meas_start_b_o = sb_q;
  assign meas_busy_o    = mbsy;
  assign data_ready_o   = tmr_done;
  assign stage_o        = stage;

  // R5: a strobe always coincides with a running pass
  a_r5_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_start_a_o || meas_start_b_o) |-> meas_busy_o);
  // R5: strobes last one cycle and never together
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({meas_start_a_o, meas_start_b_o}));
  // R2: side A strobe lands in the stage integrating on B
  a_r2_strobe_stage: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start_a_o |-> (int_b_o || !cont_mode_o));
endmodule

// File: tb/test_pingpong_seq.sv
`timescale 1ns/1ps
module test_pingpong_seq;
  localparam int SYNC = 2;
  localparam int MEAS = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv = 1'b1;
  logic       int_a, int_b, sa, sb, busy, mode, rdy;
  logic [2:0] stage;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  pingpong_seq #(.SYNC_STAGES(SYNC), .MEAS_CYCLES(MEAS)) i_pingpong_seq (
    .clk(clk), .rst_n(rst_n), .conv_i(conv),
    .int_a_o(int_a), .int_b_o(int_b),
    .meas_start_a_o(sa), .meas_start_b_o(sb),
    .meas_busy_o(busy), .cont_mode_o(mode),
    .data_ready_o(rdy), .stage_o(stage)
  );

  // cycle model built from the requirements
  logic [SYNC-1:0] m_sync = '0;
  int m_stage = 0, m_prev = 0, m_cnt = 0;
  bit m_owe = 0, m_sa = 0, m_sb = 0, m_rdy = 0;

  always @(posedge clk) begin
    bit c, mb, s_a, s_b, no;
    int nx;
    c  = m_sync[SYNC-1];
    mb = (m_cnt != 0) || m_owe;
    s_a = 0; s_b = 0; no = m_owe; nx = m_stage;
    if (!rst_n) begin
      nx = c ? 0 : 7; no = 0;
      m_cnt = 0; m_rdy = 0;
    end else begin
      case (m_stage)
        0: if (m_owe && m_cnt == 0) begin s_b = 1; no = 0; end else if (!mb) nx = 1;
        1: if (c && !mb) nx = 2;
        2: if (!c) begin nx = 3; s_a = 1; end
        3: if (c && !mb) begin nx = 4; s_b = 1; end
           else if (c && mb) begin nx = 0; no = 1; end
           else if (!mb) nx = 5;
        4: if (!c && !mb) begin nx = 3; s_a = 1; end
           else if (!c && mb) begin nx = 7; no = 1; end
           else if (!mb) nx = 2;
        5: if (c) begin nx = 4; s_b = 1; end
        6: if (!c && !mb) nx = 5;
        default: if (m_owe && m_cnt == 0) begin s_a = 1; no = 0; end else if (!mb) nx = 6;
      endcase
      m_rdy = (m_cnt == 1);
      if (s_a || s_b) m_cnt = MEAS;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
    end
    m_prev  = m_stage;
    m_stage = nx;
    m_owe   = no;
    m_sa    = s_a;
    m_sb    = s_b;
    m_sync  = {m_sync[SYNC-2:0], conv};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string stage_tag(int prev, int cur);
    if ((prev == 3 || prev == 4) && (cur == 0 || cur == 7)) return "R7";
    if (cur == 0 || cur == 7) return "R8";
    if (cur == 1 || cur == 6) return "R9";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      bit ea, eb, em;
      ea = (m_stage == 2 || m_stage == 4);
      eb = (m_stage == 3 || m_stage == 5);
      em = (m_stage >= 2 && m_stage <= 5);
      chk(int'(stage) == m_stage, stage_tag(m_prev, m_stage), "stage", stage, m_stage);
      chk(int_a == ea, "R2", "int_a", int_a, ea);
      chk(int_b == eb, "R2", "int_b", int_b, eb);
      chk(mode == em, "R2", "cont_mode", mode, em);
      chk(sa == m_sa, "R5", "start_a", sa, m_sa);
      chk(sb == m_sb, "R5", "start_b", sb, m_sb);
      chk(busy == ((m_cnt != 0) || m_owe), "R6", "busy", busy, (m_cnt != 0) || m_owe);
      chk(rdy == m_rdy, "R10", "ready", rdy, m_rdy);
    end
  end

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int hold;
      if ($urandom % 3 == 0) hold = 1 + $urandom % 8;
      else hold = 10 + $urandom % 30;
      @(negedge clk) conv = ~conv;
      repeat (hold - 1) @(negedge clk);
    end
  endtask

  task automatic reset_with(input bit lvl);
    @(negedge clk);
    rst_n = 0; conv = lvl;
    repeat (SYNC + 4) @(negedge clk);
    // R1: power-up stage follows the held conversion level
    chk(int'(stage) == (lvl ? 0 : 7), "R1", "reset stage", stage, lvl ? 0 : 7);
    chk({int_a, int_b, mode, sa, sb, busy, rdy} == 7'd0, "R1", "reset outputs",
        {int_a, int_b, mode, sa, sb, busy, rdy}, 0);
    rst_n = 1;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    conv = 1; rst_n = 0;
    repeat (SYNC + 2) @(negedge clk);
    cmp_en = 1;
    reset_with(1'b1);
    repeat (10) @(negedge clk);
    chk(stage == 3'd2, "R9", "settled in side-A stage", stage, 2);
    // R3: synchronizer delay before the stage moves
    conv = 0;
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      chk(stage == 3'd2, "R3", "stage held during sync", stage, 2);
    end
    @(negedge clk);
    chk(stage == 3'd3, "R3", "stage moved after sync", stage, 3);
    chk(sa == 1'b1, "R5", "start_a on entry", sa, 1);
    repeat (MEAS) @(negedge clk);
    chk(rdy == 1'b1, "R10", "ready after pass", rdy, 1);
    // R7: fast toggle forces an overrun
    @(negedge clk) conv = 1;
    repeat (MEAS + 4) @(negedge clk);
    conv = 0;
    @(negedge clk) conv = 1;
    repeat (SYNC + 2) @(negedge clk);
    random_phase(150);
    reset_with(1'b0);
    repeat (10) @(negedge clk);
    chk(stage == 3'd5, "R9", "settled in side-B stage", stage, 5);
    random_phase(150);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule